// File: doc/BRIEF.md
# Banked Interrupt Controller with Two-Level Pending Summary

This block collects up to 224 interrupt lines, arranged as seven banks of 32, and condenses them into two outputs: a normal request line and a fast request line. Software configures each line one bit at a time. It chooses edge or level detection, active-high/rising or active-low/falling sense, which of the two outputs the line feeds, and whether the line is enabled at all.

Configuration lives in register window 0. Window 1 holds three things: the acknowledge (write-one-to-clear) registers, the per-bank enabled status split by destination, and one summary word. That word has one bit per bank that holds a pending enabled request, with separate fields for the fast and the normal output. A handler reads the summary first, then the status word of each flagged bank only. This avoids scanning all seven banks. Reads return data combinationally from the address. A write takes effect at the clock edge on which the write strobe is high.

Top module: `banked_intc`

## Requirements
- R1: Line n belongs to bank n/32 at bit n%32. Registers are word addressed with a stride of 4 bytes per bank. In window 0, bank b of the type, polarity, routing and enable registers sits at byte offset 0x00+4b, 0x1C+4b, 0x38+4b and 0x54+4b, and each reads back what was last written.
- R2: After synchronous reset, every enable bit is 0 and every type bit is 1. Polarity, routing and pending flags are 0, the summary word is 0, and both outputs are low.
- R3: With type bit 1 (edge), a 0-to-1 change of the sense-adjusted input sets the line's pending flag at the next clock edge. Polarity 0 means a rising edge and polarity 1 a falling edge. The flag stays set after the input returns until it is acknowledged.
- R4: With type bit 0 (level), the line's status follows the sense-adjusted input with no storage. Polarity 0 means active high and polarity 1 means active low.
- R5: An enable bit of 0 keeps the line out of both status words, the summary and the outputs. An edge captured while disabled remains pending and appears as soon as the line is enabled.
- R6: A routing bit of 1 sends an enabled active line to the normal status word, read in window 1 at 0x38+4b. A routing bit of 0 sends it to the fast status word, read in window 1 at 0x1C+4b. A line never appears in both.
- R7: Writing window 1 offset 0x00+4b clears the pending flag of each bank-b line whose data bit is 1, and leaves lines with a 0 bit untouched. An edge arriving on the same clock as its clear leaves the flag set. Clearing a level line has no lasting effect while its input stays active.
- R8: The summary word at window 1 offset 0x7C has bit b (b in 0..6) set when bank b has a nonzero fast status word, and bit 8+b set when bank b has a nonzero normal status word. Bit 7 and bits 31:15 read as 0.
- R9: The normal output is the OR of summary bits 14:8, and the fast output is the OR of summary bits 6:0. Each is registered, so it changes one clock after the summary word.
- R10: In window 1, writes to the status words and the summary word have no effect, and the clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_lines | input | 224 | Raw interrupt inputs, line n at bit n |
| reg_win | input | 1 | Register window select: 0 configuration, 1 acknowledge/status |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 7 | Byte offset inside the selected window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_win/reg_addr, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
Two functions can act on the same flag in the same clock: an acknowledge write clearing a line's pending flag, and a fresh edge on that same line. The bench provokes this by raising the input and issuing the clear on the same cycle. The result is correct only if the flag, and so the normal status word, still shows the line afterwards. A related pair is a clear written to a level line whose input is still active. There the bench expects the status to stay set straight after the write.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int MAX_BANKS   = 7;
    localparam int BIDX_W      = 3;
    localparam int ADDR_W      = 7;
    localparam int GRP_IRQ_LSB = 8;
    localparam int GROUP_WORD  = 31;

    // Register region inside a window. In window 0 the four regions are
    // type, polarity, routing, enable; in window 1 they are clear, fast
    // status, normal status (the fourth is unused).
    typedef enum logic [2:0] {
        RGN_0     = 3'd0,
        RGN_1     = 3'd1,
        RGN_2     = 3'd2,
        RGN_3     = 3'd3,
        RGN_GROUP = 3'd4,
        RGN_NONE  = 3'd5
    } region_e;

    typedef struct packed {
        region_e             rgn;
        logic [BIDX_W-1:0]   bank;
    } dec_t;

    // Word index = region * nb + bank, group summary in the last word.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nb);
        dec_t d;
        int   w;
        w      = int'(a[ADDR_W-1:2]);
        d.rgn  = RGN_NONE;
        d.bank = '0;
        if (a[1:0] == 2'b00) begin
            if (w == GROUP_WORD) begin
                d.rgn = RGN_GROUP;
            end else if (w < 4 * nb) begin
                d.rgn  = region_e'(3'(w / nb));
                d.bank = BIDX_W'(w % nb);
            end
        end
        return d;
    endfunction

    // Bits that went from inactive to active since the previous cycle.
    function automatic logic [31:0] rise_bits(input logic [31:0] cur, input logic [31:0] prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 32,
    localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  dec_t                 dec,
    input  logic [BANK_W-1:0]    wdata,
    output logic [NUM_LINES-1:0] type_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] prio_q,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [BANK_W-1:0]    rdata
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (int'(dec.bank) == b);

        always_ff @(posedge clk) begin
            if (rst) begin
                type_q[b*BANK_W +: BANK_W] <= '1;
                pol_q [b*BANK_W +: BANK_W] <= '0;
                prio_q[b*BANK_W +: BANK_W] <= '0;
                mask_q[b*BANK_W +: BANK_W] <= '0;
            end else if (hit) begin
                case (dec.rgn)
                    RGN_0:   type_q[b*BANK_W +: BANK_W] <= wdata;
                    RGN_1:   pol_q [b*BANK_W +: BANK_W] <= wdata;
                    RGN_2:   prio_q[b*BANK_W +: BANK_W] <= wdata;
                    RGN_3:   mask_q[b*BANK_W +: BANK_W] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.rgn)
            RGN_0:   rdata = type_q[int'(dec.bank)*BANK_W +: BANK_W];
            RGN_1:   rdata = pol_q [int'(dec.bank)*BANK_W +: BANK_W];
            RGN_2:   rdata = prio_q[int'(dec.bank)*BANK_W +: BANK_W];
            RGN_3:   rdata = mask_q[int'(dec.bank)*BANK_W +: BANK_W];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_line_bank.sv
module intc_line_bank
    import intc_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lines,
    input  logic [BANK_W-1:0] typ,
    input  logic [BANK_W-1:0] pol,
    input  logic [BANK_W-1:0] prio,
    input  logic [BANK_W-1:0] msk,
    input  logic [BANK_W-1:0] clr,
    output logic [BANK_W-1:0] pend_o,
    output logic [BANK_W-1:0] irq_stat,
    output logic [BANK_W-1:0] fiq_stat
);

    logic [BANK_W-1:0] active;
    logic [BANK_W-1:0] active_d;
    logic [BANK_W-1:0] edge_hit;
    logic [BANK_W-1:0] pend_q;
    logic [BANK_W-1:0] raw;
    logic [BANK_W-1:0] enabled;

    // Sense adjustment: polarity 1 inverts the line.
    assign active = lines ^ pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_d <= '0;
        end else begin
            active_d <= active;
        end
    end

    assign edge_hit = rise_bits(32'(active), 32'(active_d))[BANK_W-1:0] & typ;

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | edge_hit;
        end
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_sel
        assign raw[i] = typ[i] ? pend_q[i] : active[i];
    end

    assign enabled  = raw & msk;
    assign irq_stat = enabled & prio;
    assign fiq_stat = enabled & ~prio;
    assign pend_o   = pend_q;

endmodule

// File: rtl/intc_summary.sv
module intc_summary
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 32,
    localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_stat,
    input  logic [NUM_LINES-1:0] fiq_stat,
    output logic [BANK_W-1:0]    group_word,
    output logic                 irq_o,
    output logic                 fiq_o
);

    logic [NUM_BANKS-1:0] grp_irq;
    logic [NUM_BANKS-1:0] grp_fiq;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_or
        assign grp_irq[b] = |irq_stat[b*BANK_W +: BANK_W];
        assign grp_fiq[b] = |fiq_stat[b*BANK_W +: BANK_W];
    end

    always_comb begin
        group_word = '0;
        group_word[NUM_BANKS-1:0]                    = grp_fiq;
        group_word[GRP_IRQ_LSB +: NUM_BANKS]         = grp_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |grp_irq;
            fiq_o <= |grp_fiq;
        end
    end

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 32,
    localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] int_lines,
    input  logic                 reg_win,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BANK_W-1:0]    reg_wdata,
    output logic [BANK_W-1:0]    reg_rdata,
    output logic                 irq_o,
    output logic                 fiq_o
);

    dec_t                 dec;
    logic                 cfg_we;
    logic [BANK_W-1:0]    cfg_rdata;
    logic [NUM_LINES-1:0] type_q, pol_q, prio_q, mask_q;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] pend_all;
    logic [NUM_LINES-1:0] irq_stat, fiq_stat;
    logic [BANK_W-1:0]    group_word;

    assign dec    = decode_addr(reg_addr, NUM_BANKS);
    assign cfg_we = reg_we && !reg_win;

    intc_cfg_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .dec    (dec),
        .wdata  (reg_wdata),
        .type_q (type_q),
        .pol_q  (pol_q),
        .prio_q (prio_q),
        .mask_q (mask_q),
        .rdata  (cfg_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_hit;
        assign clr_hit = reg_we && reg_win && (dec.rgn == RGN_0) && (int'(dec.bank) == b);
        assign clr_vec[b*BANK_W +: BANK_W] = clr_hit ? reg_wdata : '0;

        intc_line_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lines    (int_lines[b*BANK_W +: BANK_W]),
            .typ      (type_q   [b*BANK_W +: BANK_W]),
            .pol      (pol_q    [b*BANK_W +: BANK_W]),
            .prio     (prio_q   [b*BANK_W +: BANK_W]),
            .msk      (mask_q   [b*BANK_W +: BANK_W]),
            .clr      (clr_vec  [b*BANK_W +: BANK_W]),
            .pend_o   (pend_all [b*BANK_W +: BANK_W]),
            .irq_stat (irq_stat [b*BANK_W +: BANK_W]),
            .fiq_stat (fiq_stat [b*BANK_W +: BANK_W])
        );
    end

    intc_summary #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sum (
        .clk        (clk),
        .rst        (rst),
        .irq_stat   (irq_stat),
        .fiq_stat   (fiq_stat),
        .group_word (group_word),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (!reg_win) begin
            reg_rdata = cfg_rdata;
        end else begin
            case (dec.rgn)
                RGN_1:     reg_rdata = fiq_stat[int'(dec.bank)*BANK_W +: BANK_W];
                RGN_2:     reg_rdata = irq_stat[int'(dec.bank)*BANK_W +: BANK_W];
                RGN_GROUP: reg_rdata = group_word;
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 32,
    localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] pend_all,
    input logic [NUM_LINES-1:0] clr_vec,
    input logic [NUM_LINES-1:0] irq_stat,
    input logic [NUM_LINES-1:0] fiq_stat,
    input logic [BANK_W-1:0]    group_word,
    input logic                 irq_o,
    input logic                 fiq_o
);

    p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && pend_all == '0 && !irq_o && !fiq_o));

    p_pend_held_r3: assert property (@(posedge clk) disable iff (rst)
        ((($past(pend_all) & ~$past(clr_vec)) & ~pend_all) == '0));

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (((irq_stat | fiq_stat) & ~mask_q) == '0));

    p_route_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        ((irq_stat & fiq_stat) == '0));

    p_group_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (group_word[7] == 1'b0 && group_word[BANK_W-1:GRP_IRQ_LSB+NUM_BANKS] == '0));

    p_irq_out_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == $past(|group_word[GRP_IRQ_LSB +: NUM_BANKS])));

    p_fiq_out_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fiq_o == $past(|group_word[NUM_BANKS-1:0])));

endmodule

bind banked_intc intc_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mask_q     (mask_q),
    .pend_all   (pend_all),
    .clr_vec    (clr_vec),
    .irq_stat   (irq_stat),
    .fiq_stat   (fiq_stat),
    .group_word (group_word),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
);

// File: tb/banked_intc_test.sv
module banked_intc_test;

    localparam int NL = 224;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] lines = '0;
    logic          win = 1'b0;
    logic          we = 1'b0;
    logic [6:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_o, fiq_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    banked_intc uut (
        .clk       (clk),
        .rst       (rst),
        .int_lines (lines),
        .reg_win   (win),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    // {op(1=write), win, addr[6:0], data[31:0], expect[31:0]}
    localparam int NV = 16;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 1'b0, 7'h18, 32'h0000FFFF, 32'h0},
        {1'b0, 1'b0, 7'h18, 32'h0,        32'h0000FFFF},
        {1'b1, 1'b0, 7'h18, 32'hFFFFFFFF, 32'h0},
        {1'b0, 1'b0, 7'h00, 32'h0,        32'hFFFFFFFF},
        {1'b1, 1'b0, 7'h20, 32'hA5A5A5A5, 32'h0},
        {1'b0, 1'b0, 7'h20, 32'h0,        32'hA5A5A5A5},
        {1'b0, 1'b0, 7'h1C, 32'h0,        32'h0},
        {1'b1, 1'b0, 7'h20, 32'h0,        32'h0},
        {1'b1, 1'b0, 7'h48, 32'h12345678, 32'h0},
        {1'b0, 1'b0, 7'h48, 32'h0,        32'h12345678},
        {1'b0, 1'b0, 7'h44, 32'h0,        32'h0},
        {1'b1, 1'b0, 7'h6C, 32'h0F0F0000, 32'h0},
        {1'b0, 1'b0, 7'h6C, 32'h0,        32'h0F0F0000},
        {1'b1, 1'b0, 7'h6C, 32'h0,        32'h0},
        {1'b0, 1'b1, 7'h08, 32'h0,        32'h0},
        {1'b0, 1'b1, 7'h7C, 32'h0,        32'h0}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic w, input logic [6:0] a, input logic [31:0] d);
        win = w; addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic w, input logic [6:0] a, input logic [31:0] exp, input string what);
        win = w; addr = a;
        #1;
        check(rdata, exp, what);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd(0, 7'h54, 32'h0,        "R2 enable bank0 after reset");
        rd(0, 7'h0C, 32'hFFFFFFFF, "R2 type bank3 after reset");
        rd(0, 7'h3C, 32'h0,        "R2 routing bank1 after reset");
        rd(1, 7'h7C, 32'h0,        "R2 summary after reset");
        check({31'h0, irq_o}, 32'h0, "R2 irq_o after reset");
        check({31'h0, fiq_o}, 32'h0, "R2 fiq_o after reset");

        // R1/R10 register map table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71], VEC[i][70:64], VEC[i][63:32]);
            else rd(VEC[i][71], VEC[i][70:64], VEC[i][31:0], "R1 R10 table readback");
        end

        // R3 rising edge on line 5 routed to normal output
        wr(0, 7'h54, 32'h20);
        wr(0, 7'h38, 32'h20);
        lines[5] = 1'b1;
        @(negedge clk);
        rd(1, 7'h38, 32'h20,  "R3 R6 normal status bank0 after rise");
        rd(1, 7'h1C, 32'h0,   "R6 fast status bank0 empty");
        rd(1, 7'h7C, 32'h100, "R8 summary bit8");
        check({31'h0, irq_o}, 32'h0, "R9 irq_o not yet");
        @(negedge clk);
        check({31'h0, irq_o}, 32'h1, "R9 irq_o one clock later");
        check({31'h0, fiq_o}, 32'h0, "R9 fiq_o stays low");
        lines[5] = 1'b0;
        @(negedge clk);
        rd(1, 7'h38, 32'h20, "R3 pending latched after input drop");
        wr(1, 7'h00, 32'h0);
        rd(1, 7'h38, 32'h20, "R7 zero clear no effect");
        // R7 clear and new edge in the same cycle
        lines[5] = 1'b1;
        wr(1, 7'h00, 32'h20);
        rd(1, 7'h38, 32'h20, "R7 edge wins over same-cycle clear");
        wr(1, 7'h00, 32'h20);
        rd(1, 7'h38, 32'h0,  "R7 clear removes pending");
        check({31'h0, irq_o}, 32'h1, "R9 irq_o still high one clock");
        @(negedge clk);
        check({31'h0, irq_o}, 32'h0, "R9 irq_o drops");
        lines[5] = 1'b0;
        @(negedge clk);

        // R3 falling edge on line 70 (bank2 bit6), fast route
        lines[70] = 1'b1;
        @(negedge clk);
        wr(0, 7'h24, 32'h40);
        wr(1, 7'h08, 32'h40);
        wr(0, 7'h5C, 32'h40);
        rd(1, 7'h24, 32'h0,  "R3 no pending before falling edge");
        lines[70] = 1'b0;
        @(negedge clk);
        rd(1, 7'h24, 32'h40, "R3 R6 fast status after falling edge");
        rd(1, 7'h40, 32'h0,  "R6 normal status bank2 empty");
        rd(1, 7'h7C, 32'h4,  "R8 summary bit2");
        @(negedge clk);
        check({31'h0, fiq_o}, 32'h1, "R9 fiq_o high");
        check({31'h0, irq_o}, 32'h0, "R9 irq_o low for fast line");
        wr(1, 7'h08, 32'h40);
        rd(1, 7'h24, 32'h0,  "R7 clear fast line");

        // R4 active-low level on line 100 (bank3 bit4)
        lines[100] = 1'b1;
        @(negedge clk);
        wr(0, 7'h0C, 32'hFFFFFFEF);
        wr(0, 7'h28, 32'h10);
        wr(0, 7'h44, 32'h10);
        wr(0, 7'h60, 32'h10);
        rd(1, 7'h44, 32'h0,  "R4 inactive level line");
        lines[100] = 1'b0;
        rd(1, 7'h44, 32'h10, "R4 active-low level shows at once");
        wr(1, 7'h0C, 32'h10);
        rd(1, 7'h44, 32'h10, "R7 clear of active level line no effect");
        lines[100] = 1'b1;
        rd(1, 7'h44, 32'h0,  "R4 level status follows input");
        @(negedge clk);

        // R5 disabled edge on line 212 (bank6 bit20)
        lines[212] = 1'b1;
        @(negedge clk);
        lines[212] = 1'b0;
        @(negedge clk);
        rd(1, 7'h34, 32'h0, "R5 disabled line hidden fast");
        rd(1, 7'h50, 32'h0, "R5 disabled line hidden normal");
        rd(1, 7'h7C, 32'h0, "R5 summary empty while disabled");
        check({31'h0, fiq_o}, 32'h0, "R5 fiq_o low while disabled");
        wr(0, 7'h6C, 32'h00100000);
        rd(1, 7'h34, 32'h00100000, "R5 pending shows once enabled");
        rd(1, 7'h7C, 32'h40,       "R8 summary bit6");

        // R10 writes to status and summary ignored
        wr(1, 7'h34, 32'h0);
        rd(1, 7'h34, 32'h00100000, "R10 status write ignored");
        wr(1, 7'h7C, 32'h0);
        rd(1, 7'h7C, 32'h40,       "R10 summary write ignored");

        // R8 both fields at once
        lines[5] = 1'b1;
        @(negedge clk);
        rd(1, 7'h7C, 32'h140, "R8 fast and normal fields together");
        @(negedge clk);
        check({30'h0, irq_o, fiq_o}, 32'h3, "R9 both outputs high");

        finish_run();
    end

endmodule